// File: doc/BRIEF.md
# Split Issue Scheduler

This block is the issue stage of an out-of-order core. It holds dispatched instructions in two small queues and sends at most one of them to a single function unit each cycle. The dispatch stage presents one instruction per cycle, with its payload and its two source tags and their ready flags. The block chooses the queue from operand readiness alone. An instruction whose two sources are already available goes into the ready queue. That queue has no tag comparators and no broadcast connection. Any other instruction goes into the waiting queue, where each entry compares both of its source tags against the physical register tag broadcast each cycle.

Each queue nominates its lowest-index eligible entry. A two-way round-robin turn bit decides which queue issues when both have a candidate, so neither queue can starve the other. When only one queue has a candidate, that queue issues at once. The issue port carries the payload and a flag naming the queue it came from. Register reads, execution and renaming are done outside this block.

Top module: `split_issue_sched`

## Requirements
- R1: After reset both queues are empty, `issue_valid` and both full flags are low, and the turn bit favours the ready queue.
- R2: An accepted instruction with `disp_src0_rdy` and `disp_src1_rdy` both 1 enters the ready queue (issued later with `issue_from_q1`=0). Any other accepted instruction enters the waiting queue (`issue_from_q1`=1).
- R3: A queue's full flag is high when all its entries (default 4) are occupied at the start of the cycle. `disp_accept` is low when the target queue is full, even if the other queue has room or an entry leaves this cycle. A refused instruction is dropped.
- R4: A waiting-queue entry can issue only after both of its sources are ready. A matching broadcast marks a source ready at the clock edge, so the entry can issue no earlier than the next cycle.
- R5: A broadcast whose tag matches a pending source of the instruction being dispatched in the same cycle marks that source ready on entry.
- R6: Within a queue, the eligible entry with the lowest index is chosen. A new instruction fills the lowest-index free entry.
- R7: When both queues have a candidate, the queue not granted last time issues. When only one queue has a candidate, it issues whatever the turn. The turn changes only on a grant.
- R8: Whenever any entry is eligible, exactly one instruction issues that cycle, and its entry is free from the next edge. An entry becomes eligible no earlier than the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch presents an instruction |
| disp_payload | input | PAY_W | Opaque instruction payload |
| disp_src0_tag | input | TAG_W | Physical tag of first source |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | TAG_W | Physical tag of second source |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_accept | output | 1 | Instruction taken this cycle |
| q0_full | output | 1 | Ready queue has no free entry |
| q1_full | output | 1 | Waiting queue has no free entry |
| bcast_valid | input | 1 | A result tag is broadcast |
| bcast_tag | input | TAG_W | Broadcast physical tag |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_payload | output | PAY_W | Payload of the issued instruction |
| issue_from_q1 | output | 1 | Issued instruction came from the waiting queue |

## Verification
Each of these faults shows up at the issue or dispatch ports within a cycle or two. A lost wakeup shows as a waiting-queue instruction that never issues, or that issues one cycle late after its broadcast. A stuck turn bit shows as two grants in a row from the same queue while both have work. A stale valid bit shows as a payload issued twice, or as a full flag that refuses dispatch too early. A behavioural model of both queues is stepped alongside the design and checks every output on every cycle, under directed wakeup and ordering cases and a long pseudo-random mix that fills both queues.

// File: rtl/split_issue_sched.sv
`timescale 1ns/1ps
module split_issue_sched #(
  parameter int TAG_W    = 6,
  parameter int PAY_W    = 8,
  parameter int Q0_DEPTH = 4,
  parameter int Q1_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [PAY_W-1:0] disp_payload,
  input  logic [TAG_W-1:0] disp_src0_tag,
  input  logic             disp_src0_rdy,
  input  logic [TAG_W-1:0] disp_src1_tag,
  input  logic             disp_src1_rdy,
  output logic             disp_accept,
  output logic             q0_full,
  output logic             q1_full,
  input  logic             bcast_valid,
  input  logic [TAG_W-1:0] bcast_tag,
  output logic             issue_valid,
  output logic [PAY_W-1:0] issue_payload,
  output logic             issue_from_q1
);
  localparam int I0_W = (Q0_DEPTH > 1) ? $clog2(Q0_DEPTH) : 1;
  localparam int I1_W = (Q1_DEPTH > 1) ? $clog2(Q1_DEPTH) : 1;

  logic [Q0_DEPTH-1:0] v0;
  logic [PAY_W-1:0]    p0 [Q0_DEPTH];
  logic [Q1_DEPTH-1:0] v1, ra, rb, rdy1;
  logic [TAG_W-1:0]    ta [Q1_DEPTH];
  logic [TAG_W-1:0]    tb [Q1_DEPTH];
  logic [PAY_W-1:0]    p1 [Q1_DEPTH];
  logic                turn;

  logic            to_q1, any0, any1, pick1, hit_a, hit_b;
  logic [I0_W-1:0] s0, f0;
  logic [I1_W-1:0] s1, f1;

  assign to_q1       = !(disp_src0_rdy && disp_src1_rdy);
  assign q0_full     = &v0;
  assign q1_full     = &v1;
  assign disp_accept = disp_valid && (to_q1 ? !q1_full : !q0_full);
  assign rdy1        = v1 & ra & rb;
  assign hit_a       = bcast_valid && (bcast_tag == disp_src0_tag);
  assign hit_b       = bcast_valid && (bcast_tag == disp_src1_tag);

  always_comb begin
    any0 = 1'b0; s0 = '0; f0 = '0;
    for (int i = Q0_DEPTH-1; i >= 0; i--) begin
      if (v0[i]) begin any0 = 1'b1; s0 = I0_W'(i); end
      else f0 = I0_W'(i);
    end
  end

  always_comb begin
    any1 = 1'b0; s1 = '0; f1 = '0;
    for (int i = Q1_DEPTH-1; i >= 0; i--) begin
      if (rdy1[i]) begin any1 = 1'b1; s1 = I1_W'(i); end
      if (!v1[i]) f1 = I1_W'(i);
    end
  end

  assign pick1         = any1 && (!any0 || turn);
  assign issue_valid   = any0 || any1;
  assign issue_from_q1 = pick1;
  assign issue_payload = pick1 ? p1[s1] : p0[s0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0   <= '0;
      v1   <= '0;
      ra   <= '0;
      rb   <= '0;
      turn <= 1'b0;
    end else begin
      for (int i = 0; i < Q1_DEPTH; i++) begin
        if (v1[i] && bcast_valid && ta[i] == bcast_tag) ra[i] <= 1'b1;
        if (v1[i] && bcast_valid && tb[i] == bcast_tag) rb[i] <= 1'b1;
      end
      if (issue_valid) begin
        turn <= !pick1;
        if (pick1) v1[s1] <= 1'b0;
        else       v0[s0] <= 1'b0;
      end
      if (disp_accept && !to_q1) begin
        v0[f0] <= 1'b1;
        p0[f0] <= disp_payload;
      end
      if (disp_accept && to_q1) begin
        v1[f1] <= 1'b1;
        p1[f1] <= disp_payload;
        ta[f1] <= disp_src0_tag;
        tb[f1] <= disp_src1_tag;
        ra[f1] <= disp_src0_rdy || hit_a;
        rb[f1] <= disp_src1_rdy || hit_b;
      end
    end
  end
endmodule

module split_issue_sched_chk #(
  parameter int Q0_DEPTH = 4,
  parameter int Q1_DEPTH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                disp_valid,
  input logic                disp_accept,
  input logic                to_q1,
  input logic                q1_full,
  input logic                issue_valid,
  input logic                issue_from_q1,
  input logic [Q0_DEPTH-1:0] v0,
  input logic [Q1_DEPTH-1:0] v1,
  input logic [Q1_DEPTH-1:0] rdy1
);
  assert_q0_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_accept && !to_q1 && !(issue_valid && !issue_from_q1))
    |=> $countones(v0) == $countones($past(v0)) + 1);

  assert_q1_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_accept && to_q1 && !(issue_valid && issue_from_q1))
    |=> $countones(v1) == $countones($past(v1)) + 1);

  assert_no_accept_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && to_q1 && q1_full) |-> !disp_accept);

  assert_q1_issue_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_from_q1) |-> (|rdy1));

  assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|v0) && (|rdy1) && $past(issue_valid)) |-> issue_from_q1 != $past(issue_from_q1));

  assert_work_conserving_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|v0) || (|rdy1)) |-> issue_valid);

  assert_idle_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|v0) || (|rdy1)) |-> !issue_valid);
endmodule

bind split_issue_sched split_issue_sched_chk #(.Q0_DEPTH(Q0_DEPTH), .Q1_DEPTH(Q1_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_accept(disp_accept),
  .to_q1(to_q1), .q1_full(q1_full), .issue_valid(issue_valid),
  .issue_from_q1(issue_from_q1), .v0(v0), .v1(v1), .rdy1(rdy1)
);

// File: tb/split_issue_sched_tb.sv
`timescale 1ns/1ps
module split_issue_sched_tb;
  localparam int TAG_W = 6, PAY_W = 8, D0 = 4, D1 = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_src0_rdy = 0, disp_src1_rdy = 0, bcast_valid = 0;
  logic [PAY_W-1:0] disp_payload = '0;
  logic [TAG_W-1:0] disp_src0_tag = '0, disp_src1_tag = '0, bcast_tag = '0;
  logic disp_accept, q0_full, q1_full, issue_valid, issue_from_q1;
  logic [PAY_W-1:0] issue_payload;

  always #2.5 clk = ~clk;

  split_issue_sched #(.TAG_W(TAG_W), .PAY_W(PAY_W), .Q0_DEPTH(D0), .Q1_DEPTH(D1)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_payload(disp_payload),
    .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
    .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
    .disp_accept(disp_accept), .q0_full(q0_full), .q1_full(q1_full),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .issue_valid(issue_valid),
    .issue_payload(issue_payload), .issue_from_q1(issue_from_q1));

  int checks = 0, fails = 0;
  bit done = 0;
  bit mv0 [D0]; int mp0 [D0];
  bit mv1 [D1]; bit mra [D1]; bit mrb [D1]; int mta [D1]; int mtb [D1]; int mp1 [D1];
  bit mturn;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < D0; i++) mv0[i] = 0;
    for (int i = 0; i < D1; i++) begin mv1[i] = 0; mra[i] = 0; mrb[i] = 0; end
    mturn = 0;
  endtask

  task automatic cyc(input bit dv, input int pay, input int t0, input bit r0,
                     input int t1, input bit r1, input bit bv, input int bt, input string req);
    bit full0, full1, to1, acc, pick1, iv;
    int a0, a1, fr0, fr1, epay;
    disp_valid = dv; disp_payload = PAY_W'(pay);
    disp_src0_tag = TAG_W'(t0); disp_src0_rdy = r0;
    disp_src1_tag = TAG_W'(t1); disp_src1_rdy = r1;
    bcast_valid = bv; bcast_tag = TAG_W'(bt);
    #1;
    full0 = 1; full1 = 1; a0 = -1; a1 = -1; fr0 = -1; fr1 = -1;
    for (int i = D0-1; i >= 0; i--) begin
      if (mv0[i]) a0 = i; else begin full0 = 0; fr0 = i; end
    end
    for (int i = D1-1; i >= 0; i--) begin
      if (mv1[i] && mra[i] && mrb[i]) a1 = i;
      if (!mv1[i]) begin full1 = 0; fr1 = i; end
    end
    to1 = !(r0 && r1);
    acc = dv && (to1 ? !full1 : !full0);
    iv = (a0 >= 0) || (a1 >= 0);
    pick1 = (a1 >= 0) && ((a0 < 0) || mturn);
    epay = pick1 ? mp1[a1] : (a0 >= 0 ? mp0[a0] : 0);
    chk(req, "issue_valid", int'(issue_valid), int'(iv));
    chk(req, "disp_accept", int'(disp_accept), int'(acc));
    chk(req, "q0_full", int'(q0_full), int'(full0));
    chk(req, "q1_full", int'(q1_full), int'(full1));
    if (iv) begin
      chk(req, "issue_from_q1", int'(issue_from_q1), int'(pick1));
      chk(req, "issue_payload", int'(issue_payload), epay);
    end
    @(posedge clk);
    for (int i = 0; i < D1; i++) begin
      if (mv1[i] && bv && mta[i] == bt) mra[i] = 1;
      if (mv1[i] && bv && mtb[i] == bt) mrb[i] = 1;
    end
    if (iv) begin
      mturn = !pick1;
      if (pick1) mv1[a1] = 0; else mv0[a0] = 0;
    end
    if (acc && !to1) begin mv0[fr0] = 1; mp0[fr0] = pay; end
    if (acc && to1) begin
      mv1[fr1] = 1; mp1[fr1] = pay; mta[fr1] = t0; mtb[fr1] = t1;
      mra[fr1] = r0 || (bv && bt == t0);
      mrb[fr1] = r1 || (bv && bt == t1);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs after reset
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: ready instruction goes to the ready queue, then a waiting one
    cyc(1, 8'h11, 1, 1, 2, 1, 0, 0, "R2");
    cyc(1, 8'h22, 5, 0, 2, 1, 0, 0, "R2");
    // R4: waiting entry stays until its tag is broadcast
    idle(3, "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, 5, "R4");
    idle(2, "R4");
    // R5: broadcast in the dispatch cycle
    cyc(1, 8'h33, 4, 1, 9, 0, 1, 9, "R5");
    idle(2, "R5");
    // R6: two entries woken together leave in slot order
    cyc(1, 8'h41, 12, 0, 3, 1, 0, 0, "R6");
    cyc(1, 8'h42, 3, 1, 12, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 12, "R6");
    idle(3, "R6");
    // R7: both queues compete and alternate
    cyc(1, 8'h51, 14, 0, 14, 0, 0, 0, "R7");
    cyc(1, 8'h52, 14, 0, 1, 1, 0, 0, "R7");
    cyc(1, 8'h53, 1, 1, 1, 1, 1, 14, "R7");
    cyc(1, 8'h54, 1, 1, 1, 1, 0, 0, "R7");
    cyc(1, 8'h55, 1, 1, 1, 1, 0, 0, "R7");
    idle(6, "R7");
    // R3: fill the waiting queue, then stall while the ready queue is empty
    for (int k = 0; k < 5; k++) cyc(1, 8'h60 + k, 20 + k, 0, 1, 1, 0, 0, "R3");
    cyc(1, 8'h6f, 30, 0, 1, 1, 0, 0, "R3");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, 1, 20 + k, "R3");
    idle(3, "R8");
    // R3 and R8: long mixed traffic that fills both queues
    void'($urandom(7));
    for (int k = 0; k < 600; k++) begin
      cyc(($urandom % 5) != 0, k & 255, $urandom % 8, ($urandom % 3) != 0,
          $urandom % 8, ($urandom % 3) != 0, ($urandom % 3) == 0, $urandom % 8,
          (k % 2) ? "R3" : "R8");
    end
    idle(10, "R8");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule